// File: doc/BRIEF.md
# Processor Debug Mode Entry Controller

This block decides when a simple in-order core is stopped in a halted debug mode and when it is let go again. A three-bit control register, loaded from the update stage of a scan-style debug port, carries a wakeup-force bit, a breakpoint-enable bit and a debug-request bit. Together with an external debug-request pin and a breakpoint pseudo-instruction indication from decode, these bits form the sources of a halt request.

All request sources are merged into one pending flag. The flag waits for the instruction-boundary strobe, so the core never stops in the middle of an instruction. While halted, the core is released only by an exit command that follows a completed update scan of the core state register. The block also drives a wakeup request to the clock controller and a debug-mode status bit for the instruction-register capture data.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While control bit 2 (debug request) is set and the core runs, the cycle with `insn_boundary` high is followed by `core_halt` high at the next clock.
- R2: `core_halt` rises only in the clock after a cycle with `insn_boundary` high. A request without a boundary waits and does not halt.
- R3: When control bit 1 (breakpoint enable) and `dbg_global_en` are both set, `bkpt_hit` acts exactly like the external debug request.
- R4: If either control bit 1 or `dbg_global_en` is clear, `bkpt_hit` is neither acted on nor remembered, so `core_halt` stays low across that boundary and the ones after it.
- R5: `wake_req` equals control bit 0 (wakeup force) from the clock after the register write, whether or not the core is halted.
- R6: `ir_cap_dbg` is high exactly while the core is in debug mode.
- R7: An `exit_cmd` that arrives before any `state_upd_done` since the latest entry is ignored, and `core_halt` stays high.
- R8: An `exit_cmd` that arrives after an update scan drops `core_halt` at the next clock and uses up the update. A later entry needs a new update before it can exit.
- R9: After synchronous reset the control register reads 0 on `cfg_rd_data`, and `core_halt`, `wake_req` and `ir_cap_dbg` are low.
- R10: If control bit 2 is still set when the core exits, the core halts again at the next boundary.
- R11: A single-cycle `ext_dbg_req` pulse is held pending until the next boundary, and the core then halts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Scan update strobe for the control register |
| cfg_wr_data | input | 3 | New control value: bit0 wake force, bit1 breakpoint enable, bit2 debug request |
| cfg_rd_data | output | 3 | Current control register value for scan capture |
| ext_dbg_req | input | 1 | External debug request |
| bkpt_hit | input | 1 | Breakpoint pseudo-instruction executed |
| insn_boundary | input | 1 | Instruction boundary strobe |
| dbg_global_en | input | 1 | Global debug enable that qualifies breakpoint enable |
| state_upd_done | input | 1 | Core state register update scan completed |
| exit_cmd | input | 1 | Leave-debug command |
| core_halt | output | 1 | Halt to the core pipeline |
| wake_req | output | 1 | Wakeup request to the clock controller |
| ir_cap_dbg | output | 1 | Debug-mode status for IR capture |

## Verification
Every result is one register stage from its cause. `core_halt` and `ir_cap_dbg` change in the clock after the boundary or exit cycle. `wake_req` and `cfg_rd_data` change in the clock after the write strobe. The bench drives inputs on the falling edge and advances its reference model on the rising edge, using the inputs seen there. It then compares all outputs on the next falling edge, so each expectation is sampled exactly one clock after its stimulus. Directed checks also assert fixed values at those same points for the waiting, gating and re-entry cases.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    localparam int CTRL_W   = 3;
    localparam int WAKE_BIT = 0;
    localparam int BKPT_BIT = 1;
    localparam int REQ_BIT  = 2;

    typedef struct packed {
        logic dbg_req;
        logic bkpt_en;
        logic wake_force;
    } dbg_ctrl_t;

    typedef enum logic [0:0] {
        CORE_RUN  = 1'b0,
        CORE_HALT = 1'b1
    } core_mode_e;

    function automatic logic bkpt_qualified(input logic hit, input logic bkpt_en, input logic global_en);
        return hit & bkpt_en & global_en;
    endfunction

endpackage

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
    import dbg_halt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output dbg_ctrl_t         ctrl,
    output logic              wake_req
);

    dbg_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr_en)
            ctrl_q <= dbg_ctrl_t'(wr_data);
    end

    assign ctrl     = ctrl_q;
    assign wake_req = ctrl_q.wake_force;

    AST_WAKE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (wake_req == $past(wr_data[WAKE_BIT]))); // R5

endmodule

// File: rtl/dbg_req_merge.sv
module dbg_req_merge
    import dbg_halt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic halted,
    input  logic boundary,
    input  logic ctrl_req,
    input  logic ctrl_bkpt_en,
    input  logic global_en,
    input  logic bkpt_hit,
    input  logic ext_req,
    output logic enter
);

    logic pend_q;
    logic req_now;

    always_comb begin
        req_now = ctrl_req | ext_req | bkpt_qualified(bkpt_hit, ctrl_bkpt_en, global_en);
        enter   = !halted && boundary && (pend_q || req_now);
    end

    always_ff @(posedge clk) begin
        if (rst || halted || enter)
            pend_q <= 1'b0;
        else
            pend_q <= pend_q | req_now;
    end

    AST_PEND_CLEAR_IN_DEBUG: assert property (@(posedge clk) disable iff (rst)
        halted |=> !pend_q); // R11

endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import dbg_halt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic enter,
    input  logic boundary,
    input  logic exit_cmd,
    input  logic upd_done,
    output logic halted
);

    core_mode_e mode_q;
    logic       upd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= CORE_RUN;
            upd_q  <= 1'b0;
        end else begin
            case (mode_q)
                CORE_RUN: begin
                    upd_q <= 1'b0;
                    if (enter)
                        mode_q <= CORE_HALT;
                end
                CORE_HALT: begin
                    if (exit_cmd && upd_q) begin
                        mode_q <= CORE_RUN;
                        upd_q  <= 1'b0;
                    end else if (upd_done) begin
                        upd_q  <= 1'b1;
                    end
                end
                default: mode_q <= CORE_RUN;
            endcase
        end
    end

    assign halted = (mode_q == CORE_HALT);

    AST_HALT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> $past(boundary)); // R2

    AST_EXIT_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $fell(halted) |-> $past(exit_cmd && upd_q)); // R7

    AST_UPDATE_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        $fell(halted) |-> !upd_q); // R8

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [CTRL_W-1:0] cfg_wr_data,
    output logic [CTRL_W-1:0] cfg_rd_data,
    input  logic              ext_dbg_req,
    input  logic              bkpt_hit,
    input  logic              insn_boundary,
    input  logic              dbg_global_en,
    input  logic              state_upd_done,
    input  logic              exit_cmd,
    output logic              core_halt,
    output logic              wake_req,
    output logic              ir_cap_dbg
);

    dbg_ctrl_t ctrl;
    logic      enter;
    logic      halted;

    dbg_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .ctrl     (ctrl),
        .wake_req (wake_req)
    );

    dbg_req_merge u_merge (
        .clk          (clk),
        .rst          (rst),
        .halted       (halted),
        .boundary     (insn_boundary),
        .ctrl_req     (ctrl.dbg_req),
        .ctrl_bkpt_en (ctrl.bkpt_en),
        .global_en    (dbg_global_en),
        .bkpt_hit     (bkpt_hit),
        .ext_req      (ext_dbg_req),
        .enter        (enter)
    );

    dbg_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .enter    (enter),
        .boundary (insn_boundary),
        .exit_cmd (exit_cmd),
        .upd_done (state_upd_done),
        .halted   (halted)
    );

    assign cfg_rd_data = CTRL_W'(ctrl);
    assign core_halt   = halted;
    assign ir_cap_dbg  = halted;

    AST_REQ_BIT_ENTERS: assert property (@(posedge clk) disable iff (rst)
        (!core_halt && insn_boundary && ctrl.dbg_req) |=> core_halt); // R1

endmodule

// File: tb/dbg_halt_ctrl_test.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr_en;
    logic [2:0] cfg_wr_data;
    logic [2:0] cfg_rd_data;
    logic       ext_dbg_req, bkpt_hit, insn_boundary, dbg_global_en;
    logic       state_upd_done, exit_cmd;
    logic       core_halt, wake_req, ir_cap_dbg;

    always #2.5 clk = ~clk;

    dbg_halt_ctrl uut (
        .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .ext_dbg_req(ext_dbg_req), .bkpt_hit(bkpt_hit),
        .insn_boundary(insn_boundary), .dbg_global_en(dbg_global_en),
        .state_upd_done(state_upd_done), .exit_cmd(exit_cmd),
        .core_halt(core_halt), .wake_req(wake_req), .ir_cap_dbg(ir_cap_dbg)
    );

    int checks = 0;
    int errors = 0;
    bit timed_out = 1'b0;

    // behavioural reference state
    bit       m_halt, m_pend, m_upd;
    bit [2:0] m_ctrl;

    task automatic expect_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        bit req;
        if (rst) begin
            m_halt = 0; m_pend = 0; m_upd = 0; m_ctrl = 3'b000;
        end else begin
            req = m_ctrl[2] | ext_dbg_req | (bkpt_hit & m_ctrl[1] & dbg_global_en);
            if (!m_halt) begin
                m_upd = 0;
                if (insn_boundary && (m_pend || req)) begin
                    m_halt = 1; m_pend = 0;
                end else begin
                    m_pend = m_pend | req;
                end
            end else begin
                m_pend = 0;
                if (exit_cmd && m_upd) begin
                    m_halt = 0; m_upd = 0;
                end else if (state_upd_done) begin
                    m_upd = 1;
                end
            end
            if (cfg_wr_en) m_ctrl = cfg_wr_data;
        end
    endtask

    task automatic compare_model();
        expect_eq("R2 halt vs model", {7'd0, core_halt}, {7'd0, m_halt});
        expect_eq("R5 wake vs model", {7'd0, wake_req}, {7'd0, m_ctrl[0]});
        expect_eq("R6 status vs model", {7'd0, ir_cap_dbg}, {7'd0, m_halt});
        expect_eq("R9 readback vs model", {5'd0, cfg_rd_data}, {5'd0, m_ctrl});
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_model();
    endtask

    task automatic write_ctrl(input logic [2:0] v);
        cfg_wr_en = 1; cfg_wr_data = v;
        step();
        cfg_wr_en = 0; cfg_wr_data = 3'b000;
    endtask

    task automatic pulse_boundary();
        insn_boundary = 1; step(); insn_boundary = 0;
    endtask

    task automatic do_release();
        state_upd_done = 1; step(); state_upd_done = 0;
        exit_cmd = 1; step(); exit_cmd = 0;
    endtask

    task automatic run_all();
        logic [15:0] lfsr;
        rst = 1; cfg_wr_en = 0; cfg_wr_data = 0; ext_dbg_req = 0; bkpt_hit = 0;
        insn_boundary = 0; dbg_global_en = 0; state_upd_done = 0; exit_cmd = 0;
        for (int i = 0; i < 4; i++) step();
        rst = 0;
        step();
        expect_eq("R9 halt after reset", {7'd0, core_halt}, 8'd0);
        expect_eq("R9 wake after reset", {7'd0, wake_req}, 8'd0);
        expect_eq("R9 status after reset", {7'd0, ir_cap_dbg}, 8'd0);
        expect_eq("R9 ctrl after reset", {5'd0, cfg_rd_data}, 8'd0);

        write_ctrl(3'b001);
        expect_eq("R5 wake set", {7'd0, wake_req}, 8'd1);
        write_ctrl(3'b000);
        expect_eq("R5 wake cleared", {7'd0, wake_req}, 8'd0);

        // R1 / R2: request waits for a boundary
        write_ctrl(3'b100);
        step(); step();
        expect_eq("R2 no halt without boundary", {7'd0, core_halt}, 8'd0);
        pulse_boundary();
        expect_eq("R1 halt after boundary", {7'd0, core_halt}, 8'd1);
        expect_eq("R6 status in debug", {7'd0, ir_cap_dbg}, 8'd1);

        // R7: exit without update ignored
        exit_cmd = 1; step(); exit_cmd = 0; step();
        expect_eq("R7 exit without update", {7'd0, core_halt}, 8'd1);

        // R8 then R10: release with bit still set, re-entry
        do_release();
        expect_eq("R8 halt drops after exit", {7'd0, core_halt}, 8'd0);
        pulse_boundary();
        expect_eq("R10 re-entry with bit set", {7'd0, core_halt}, 8'd1);
        exit_cmd = 1; step(); exit_cmd = 0;
        expect_eq("R8 update consumed", {7'd0, core_halt}, 8'd1);

        write_ctrl(3'b000);
        do_release();
        pulse_boundary();
        expect_eq("R10 no re-entry once cleared", {7'd0, core_halt}, 8'd0);

        // R4: breakpoint gating
        write_ctrl(3'b010);
        dbg_global_en = 0; bkpt_hit = 1; pulse_boundary(); bkpt_hit = 0;
        expect_eq("R4 bkpt without global enable", {7'd0, core_halt}, 8'd0);
        pulse_boundary();
        expect_eq("R4 bkpt not remembered", {7'd0, core_halt}, 8'd0);
        write_ctrl(3'b000);
        dbg_global_en = 1; bkpt_hit = 1; pulse_boundary(); bkpt_hit = 0;
        expect_eq("R4 bkpt without bkpt enable", {7'd0, core_halt}, 8'd0);

        // R3: both enables
        write_ctrl(3'b010);
        bkpt_hit = 1; pulse_boundary(); bkpt_hit = 0;
        expect_eq("R3 qualified breakpoint halts", {7'd0, core_halt}, 8'd1);
        do_release();
        write_ctrl(3'b000);

        // R11: pulse held pending
        ext_dbg_req = 1; step(); ext_dbg_req = 0;
        step(); step();
        expect_eq("R11 pulse waits", {7'd0, core_halt}, 8'd0);
        pulse_boundary();
        expect_eq("R11 pending pulse halts", {7'd0, core_halt}, 8'd1);
        write_ctrl(3'b001);
        expect_eq("R5 wake while halted", {7'd0, wake_req}, 8'd1);
        write_ctrl(3'b000);
        do_release();

        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            insn_boundary  = lfsr[0] & lfsr[3];
            ext_dbg_req    = lfsr[1] & lfsr[5] & lfsr[9];
            bkpt_hit       = lfsr[2] & lfsr[7];
            dbg_global_en  = lfsr[4] | lfsr[11];
            state_upd_done = lfsr[6] & lfsr[8];
            exit_cmd       = lfsr[10] & lfsr[12];
            cfg_wr_en      = lfsr[13] & lfsr[14] & lfsr[15];
            cfg_wr_data    = lfsr[2:0];
            step();
        end
        cfg_wr_en = 0; insn_boundary = 0; ext_dbg_req = 0; bkpt_hit = 0;
        state_upd_done = 0; exit_cmd = 0;
        step();
    endtask

    initial begin
        fork
            run_all();
            begin
                #(200000 * 5);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule